// File: doc/BRIEF.md
# NaN Propagation Selector

This block sits at the result stage of a two-operand single-precision floating-point unit. It takes both source operands, the result the arithmetic datapath has already produced, an invalid indication from that datapath and a three-bit policy code. When either source operand is a NaN, it picks which NaN is written back, following the rule that the policy code selects. Any signalling NaN it forwards is first made quiet. It raises an invalid-operation flag and, when traps are enabled, a trap request.

Five rules are available at run time. Three give precedence by operand position. One gives precedence to signalling NaNs. The last always returns one fixed canonical NaN, so the result never depends on which operand came first. Results, flags and valid pass through one register stage.

Top module: `nan_select`

## Requirements
- R1: A word is a NaN when exponent bits 30:23 are all ones and mantissa bits 22:0 are nonzero. It is quiet when bit 22 is 1 and signalling when bit 22 is 0. When an operand NaN is forwarded, bit 22 is set and the sign and all other payload bits are kept, so the output is never a signalling NaN.
- R2: Policy code 0 forwards operand A when A is a NaN, and otherwise forwards operand B.
- R3: Policy code 1 forwards operand B when B is a NaN, and otherwise forwards operand A.
- R4: Policy code 2, with both operands NaN, forwards A when B is signalling and forwards B otherwise. With exactly one operand NaN, it forwards that operand.
- R5: Policy code 3, with both operands NaN, forwards whichever operand is signalling. A wins when both are signalling or both are quiet. With exactly one operand NaN, it forwards that operand.
- R6: Policy code 4, and the unused codes 5 to 7, output 0x7FC00000 whenever either operand is a NaN, whatever the payloads.
- R7: When neither operand is a NaN, the datapath result passes unchanged. If that datapath result is itself a NaN, 0x7FC00000 is output in its place.
- R8: The invalid flag is set when either operand is a signalling NaN or the datapath invalid input is high.
- R9: The trap request is high exactly when the invalid flag is high and trap enable was high on the same input cycle.
- R10: Valid out equals valid in from one clock earlier. The invalid flag and trap request are low whenever valid out is low.
- R11: A synchronous active-high reset clears valid out, the invalid flag and the trap request on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| validIn | input | 1 | Input operands and datapath result are valid |
| opA | input | 32 | First source operand |
| opB | input | 32 | Second source operand |
| dpResult | input | 32 | Result computed by the arithmetic datapath |
| dpInvalid | input | 1 | Datapath detected an invalid operation |
| policy | input | 3 | NaN precedence rule, codes 0 to 4 (5 to 7 act as 4) |
| trapEn | input | 1 | Invalid-operation trap enable |
| validOut | output | 1 | Registered result is valid |
| result | output | 32 | Registered selected result |
| invalidFlag | output | 1 | Invalid-operation flag for the output |
| trapReq | output | 1 | Trap request for the output |

## Verification
The assertions check the timing and flag behaviour on every cycle: valid out follows valid in, flags are gated by valid, the trap implies the invalid flag, reset clears state, the output is never a signalling NaN, and the canonical, pass-through and first-operand rules hold. The precedence choices of the second-operand, second-quiet and signalling-precedence rules need the bench's sweep to show them. That sweep covers every pairing of number, infinity, quiet NaN and signalling NaN across all eight policy codes, with both a NaN and a normal datapath result, and it compares each output against a model computed in the bench.

// File: rtl/nan_select_pkg.sv
package nan_select_pkg;

  typedef enum logic [2:0] {
    POL_FIRST        = 3'd0,
    POL_SECOND       = 3'd1,
    POL_SECOND_QUIET = 3'd2,
    POL_SIG_FIRST    = 3'd3,
    POL_CANON        = 3'd4
  } policy_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic pickA;
    logic pickB;
    logic pickCanon;
    logic pickPass;
    logic load;
    logic invalid;
    logic trap;
  } sel_strobe_t;

  typedef struct packed {
    logic isNan;
    logic isSig;
  } op_class_t;

endpackage

// File: rtl/nan_select_class.sv
module nan_select_class
  import nan_select_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] value,
  output op_class_t            cls
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic [EXP_W-1:0] expField;
  logic [MAN_W-1:0] manField;

  assign expField = value[W-2:MAN_W];
  assign manField = value[MAN_W-1:0];

  always_comb begin
    cls.isNan = (&expField) && (|manField);
    cls.isSig = cls.isNan && !manField[MAN_W-1];
  end
endmodule

// File: rtl/nan_select_ctrl.sv
module nan_select_ctrl
  import nan_select_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                   validIn,
  input  logic [EXP_W+MAN_W:0]   opA,
  input  logic [EXP_W+MAN_W:0]   opB,
  input  logic [EXP_W+MAN_W:0]   dpResult,
  input  logic                   dpInvalid,
  input  logic [2:0]             policy,
  input  logic                   trapEn,
  output sel_strobe_t            strobe
);
  localparam int W      = 1 + EXP_W + MAN_W;
  localparam int N_WORD = 3;

  logic [W-1:0] words [N_WORD];
  op_class_t    cls   [N_WORD];

  assign words[0] = opA;
  assign words[1] = opB;
  assign words[2] = dpResult;

  for (genvar i = 0; i < N_WORD; i++) begin : g_class
    nan_select_class #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_class (
      .value(words[i]),
      .cls  (cls[i])
    );
  end

  logic aNan, bNan, aSig, bSig, resNan;
  assign aNan   = cls[0].isNan;
  assign bNan   = cls[1].isNan;
  assign aSig   = cls[0].isSig;
  assign bSig   = cls[1].isSig;
  assign resNan = cls[2].isNan;

  policy_e pol;
  assign pol = policy_e'(policy);

  logic takeA, takeB, takeCanon, takePass;

  always_comb begin
    takeA     = 1'b0;
    takeB     = 1'b0;
    takeCanon = 1'b0;
    takePass  = 1'b0;
    if (!(aNan || bNan)) begin
      takeCanon = resNan;
      takePass  = !resNan;
    end else begin
      unique case (pol)
        POL_FIRST: begin
          takeA = aNan;
          takeB = !aNan;
        end
        POL_SECOND: begin
          takeB = bNan;
          takeA = !bNan;
        end
        POL_SECOND_QUIET: begin
          if (aNan && bNan) takeA = bSig;
          else              takeA = aNan;
          takeB = !takeA;
        end
        POL_SIG_FIRST: begin
          if (aNan && bNan) takeA = aSig || !bSig;
          else              takeA = aNan;
          takeB = !takeA;
        end
        default: takeCanon = 1'b1;
      endcase
    end
  end

  always_comb begin
    strobe.pickA     = takeA;
    strobe.pickB     = takeB;
    strobe.pickCanon = takeCanon;
    strobe.pickPass  = takePass;
    strobe.load      = validIn;
    strobe.invalid   = aSig || bSig || dpInvalid;
    strobe.trap      = (aSig || bSig || dpInvalid) && trapEn;
  end
endmodule

// File: rtl/nan_select_dp.sv
module nan_select_dp
  import nan_select_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [EXP_W+MAN_W:0] opA,
  input  logic [EXP_W+MAN_W:0] opB,
  input  logic [EXP_W+MAN_W:0] dpResult,
  input  sel_strobe_t          strobe,
  output logic                 validOut,
  output logic [EXP_W+MAN_W:0] result,
  output logic                 invalidFlag,
  output logic                 trapReq
);
  localparam int           W          = 1 + EXP_W + MAN_W;
  localparam logic [W-1:0] QUIET_MASK = W'(1) << (MAN_W - 1);
  localparam logic [W-1:0] CANON_NAN  = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic [W-1:0] chosen;

  always_comb begin
    if (strobe.pickA)          chosen = opA | QUIET_MASK;
    else if (strobe.pickB)     chosen = opB | QUIET_MASK;
    else if (strobe.pickCanon) chosen = CANON_NAN;
    else                       chosen = dpResult;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validOut    <= 1'b0;
      invalidFlag <= 1'b0;
      trapReq     <= 1'b0;
      result      <= '0;
    end else begin
      validOut    <= strobe.load;
      invalidFlag <= strobe.load && strobe.invalid;
      trapReq     <= strobe.load && strobe.trap;
      if (strobe.load) result <= chosen;
    end
  end
endmodule

// File: rtl/nan_select.sv
module nan_select
  import nan_select_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 validIn,
  input  logic [EXP_W+MAN_W:0] opA,
  input  logic [EXP_W+MAN_W:0] opB,
  input  logic [EXP_W+MAN_W:0] dpResult,
  input  logic                 dpInvalid,
  input  logic [2:0]           policy,
  input  logic                 trapEn,
  output logic                 validOut,
  output logic [EXP_W+MAN_W:0] result,
  output logic                 invalidFlag,
  output logic                 trapReq
);
  sel_strobe_t strobe;

  nan_select_ctrl #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_ctrl (
    .validIn  (validIn),
    .opA      (opA),
    .opB      (opB),
    .dpResult (dpResult),
    .dpInvalid(dpInvalid),
    .policy   (policy),
    .trapEn   (trapEn),
    .strobe   (strobe)
  );

  nan_select_dp #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .opA        (opA),
    .opB        (opB),
    .dpResult   (dpResult),
    .strobe     (strobe),
    .validOut   (validOut),
    .result     (result),
    .invalidFlag(invalidFlag),
    .trapReq    (trapReq)
  );
endmodule

// File: rtl/nan_select_checker.sv
module nan_select_checker #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 validIn,
  input logic [EXP_W+MAN_W:0] opA,
  input logic [EXP_W+MAN_W:0] opB,
  input logic [EXP_W+MAN_W:0] dpResult,
  input logic                 dpInvalid,
  input logic [2:0]           policy,
  input logic                 trapEn,
  input logic                 validOut,
  input logic [EXP_W+MAN_W:0] result,
  input logic                 invalidFlag,
  input logic                 trapReq
);
  localparam int           W          = 1 + EXP_W + MAN_W;
  localparam logic [W-1:0] QUIET_MASK = W'(1) << (MAN_W - 1);
  localparam logic [W-1:0] CANON_NAN  = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  function automatic logic nanOf(input logic [W-1:0] x);
    return (&x[W-2:MAN_W]) && (|x[MAN_W-1:0]);
  endfunction

  function automatic logic sigOf(input logic [W-1:0] x);
    return nanOf(x) && !x[MAN_W-1];
  endfunction

  logic aNan, bNan, rNan, anySig, outSig;
  assign aNan   = nanOf(opA);
  assign bNan   = nanOf(opB);
  assign rNan   = nanOf(dpResult);
  assign anySig = sigOf(opA) || sigOf(opB);
  assign outSig = sigOf(result);

  p_reset_clears_r11: assert property (@(posedge clk)
    rst |=> (!validOut && !invalidFlag && !trapReq));

  p_valid_follow_r10: assert property (@(posedge clk) disable iff (rst)
    validIn |=> validOut);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !validIn |=> (!validOut && !invalidFlag && !trapReq));

  p_invalid_raise_r8: assert property (@(posedge clk) disable iff (rst)
    (validIn && (anySig || dpInvalid)) |=> invalidFlag);

  p_trap_implies_invalid_r9: assert property (@(posedge clk) disable iff (rst)
    trapReq |-> invalidFlag);

  p_trap_raise_r9: assert property (@(posedge clk) disable iff (rst)
    (validIn && trapEn && (anySig || dpInvalid)) |=> trapReq);

  p_no_signalling_out_r1: assert property (@(posedge clk) disable iff (rst)
    validOut |-> !outSig);

  p_canonical_r6: assert property (@(posedge clk) disable iff (rst)
    (validIn && policy >= 3'd4 && (aNan || bNan)) |=> (result == CANON_NAN));

  p_passthrough_r7: assert property (@(posedge clk) disable iff (rst)
    (validIn && !aNan && !bNan && !rNan) |=> (result == $past(dpResult)));

  p_first_wins_r2: assert property (@(posedge clk) disable iff (rst)
    (validIn && policy == 3'd0 && aNan) |=> (result == ($past(opA) | QUIET_MASK)));
endmodule

bind nan_select nan_select_checker #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_checker (
  .clk        (clk),
  .rst        (rst),
  .validIn    (validIn),
  .opA        (opA),
  .opB        (opB),
  .dpResult   (dpResult),
  .dpInvalid  (dpInvalid),
  .policy     (policy),
  .trapEn     (trapEn),
  .validOut   (validOut),
  .result     (result),
  .invalidFlag(invalidFlag),
  .trapReq    (trapReq)
);

// File: tb/nan_select_bench.sv
module nan_select_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        validIn;
  logic [31:0] opA, opB, dpResult;
  logic        dpInvalid;
  logic [2:0]  policy;
  logic        trapEn;
  logic        validOut;
  logic [31:0] result;
  logic        invalidFlag;
  logic        trapReq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  nan_select u_nan_select (
    .clk(clk), .rst(rst), .validIn(validIn), .opA(opA), .opB(opB),
    .dpResult(dpResult), .dpInvalid(dpInvalid), .policy(policy), .trapEn(trapEn),
    .validOut(validOut), .result(result), .invalidFlag(invalidFlag), .trapReq(trapReq)
  );

  localparam logic [31:0] CANON = 32'h7FC0_0000;

  // Operand pools: number, quiet NaN, signalling NaN, infinity
  function automatic logic [31:0] poolA(input int i);
    case (i)
      0: return 32'h3F80_0000;
      1: return 32'h7FC1_2345;
      2: return 32'hFF81_2345;
      default: return 32'h7F80_0000;
    endcase
  endfunction

  function automatic logic [31:0] poolB(input int i);
    case (i)
      0: return 32'hC000_0000;
      1: return 32'hFFC0_ABCD;
      2: return 32'h7F80_ABCD;
      default: return 32'hFF80_0000;
    endcase
  endfunction

  function automatic bit isNan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 23'd0);
  endfunction

  function automatic bit isSig(input logic [31:0] x);
    return isNan(x) && !x[22];
  endfunction

  function automatic logic [31:0] quieten(input logic [31:0] x);
    return x | 32'h0040_0000;
  endfunction

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [31:0] r, input int pol);
    bit aN = isNan(a);
    bit bN = isNan(b);
    bit aS = isSig(a);
    bit bS = isSig(b);
    if (!aN && !bN) return isNan(r) ? CANON : r;
    if (pol >= 4) return CANON;
    case (pol)
      0: return aN ? quieten(a) : quieten(b);
      1: return bN ? quieten(b) : quieten(a);
      2: if (aN && bN) return bS ? quieten(a) : quieten(b);
         else return aN ? quieten(a) : quieten(b);
      default: if (aN && bN) return (aS || !bS) ? quieten(a) : quieten(b);
               else return aN ? quieten(a) : quieten(b);
    endcase
  endfunction

  function automatic string policyTag(input logic [31:0] a, input logic [31:0] b, input int pol);
    if (!isNan(a) && !isNan(b)) return "R7";
    case (pol)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finishRun;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL R10: watchdog expired, actual running expected finished");
      finishRun();
    end
  end

  initial begin
    rst = 1'b1; validIn = 1'b1; opA = 32'hFF81_2345; opB = 32'h0;
    dpResult = 32'h0; dpInvalid = 1'b1; policy = 3'd0; trapEn = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset clears outputs even with valid, invalid and trap inputs active
    check("R11 validOut", {31'd0, validOut}, 32'd0);
    check("R11 invalidFlag", {31'd0, invalidFlag}, 32'd0);
    check("R11 trapReq", {31'd0, trapReq}, 32'd0);
    rst = 1'b0;

    for (int ia = 0; ia < 4; ia++) begin
      for (int ib = 0; ib < 4; ib++) begin
        for (int pol = 0; pol < 8; pol++) begin
          for (int k = 0; k < 4; k++) begin
            for (int rs = 0; rs < 2; rs++) begin
              logic [31:0] a, b, r;
              bit expInv, expTrap;
              a = poolA(ia);
              b = poolB(ib);
              r = (rs == 0) ? 32'h4040_0000 : 32'h7FC0_0001;
              validIn = 1'b1; opA = a; opB = b; dpResult = r;
              dpInvalid = k[0]; trapEn = k[1]; policy = 3'(pol);
              expInv  = isSig(a) || isSig(b) || k[0];
              expTrap = expInv && k[1];
              @(posedge clk);
              @(negedge clk);
              check(policyTag(a, b, pol), result, model(a, b, r, pol));
              check("R8 invalidFlag", {31'd0, invalidFlag}, {31'd0, expInv});
              check("R9 trapReq", {31'd0, trapReq}, {31'd0, expTrap});
              check("R10 validOut", {31'd0, validOut}, 32'd1);
              if (isNan(result)) check("R1 quiet bit", {31'd0, result[22]}, 32'd1);
            end
          end
        end
      end
    end

    // R10: idle cycle with invalid-looking inputs raises nothing, result holds
    begin
      logic [31:0] held;
      held = result;
      validIn = 1'b0; opA = 32'h7F80_0001; dpInvalid = 1'b1; trapEn = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R10 idle validOut", {31'd0, validOut}, 32'd0);
      check("R10 idle invalidFlag", {31'd0, invalidFlag}, 32'd0);
      check("R10 idle trapReq", {31'd0, trapReq}, 32'd0);
      check("R10 idle result hold", result, held);
    end

    // R1: sign and payload kept on a quieted signalling NaN
    validIn = 1'b1; opA = 32'hFFA0_0001; opB = 32'h3F80_0000; dpInvalid = 1'b0;
    trapEn = 1'b0; policy = 3'd0;
    @(posedge clk);
    @(negedge clk);
    check("R1 payload kept", result, 32'hFFE0_0001);

    // R11: mid-stream reset
    rst = 1'b1; opA = 32'h7F80_0001;
    @(posedge clk);
    @(negedge clk);
    check("R11 mid validOut", {31'd0, validOut}, 32'd0);
    check("R11 mid invalidFlag", {31'd0, invalidFlag}, 32'd0);
    rst = 1'b0; validIn = 1'b0;
    @(negedge clk);

    done = 1'b1;
    finishRun();
  end
endmodule